// File: doc/BRIEF.md
# Cascaded Timer and Compare Cell Chain

This block is a row of timer cells that share one timer bus. The first cell is a 16-bit up-counter. It advances only while a clock-enable input is high. The counter runs in one of two modes. In free mode it wraps naturally. In restart mode a flagged compare cell forces it back to 0xFFFF, and that sets the PWM period. Each compare cell after the counter watches the timer bus. When it matches, it applies a set, clear, toggle, hold or copy action to a signal bit. The chain passes that bit from cell to cell.

Cells are linked in groups. A linked cell adopts its neighbour's new value whenever the neighbour fires. When both act in the same cycle, the linked cell's own action is applied last and therefore wins. Leading and trailing edges of edge-aligned or center-aligned PWM waveforms come from groups of two cells. The last cell of a group drives an output pin. Every compare cell carries an enable qualifier taken from an external select line.

Top module: `tcc_chain`

## Requirements
- R1: A synchronous active-high reset loads the timer with 0x0000, drives every cell output low, and returns every cell to its default configuration: hold action, always-enabled qualifier, no restart flag, not linked, compare value 0xFFFF.
- R2: The timer increments by one on each clock where `cnt_en` is high. While `cnt_en` is low the timer and all cell outputs keep their values.
- R3: With `tmr_mode` = 0 (free mode) the timer wraps from 0xFFFF to 0x0000, and restart flags have no effect on the timer.
- R4: With `tmr_mode` = 1, a compare cell that has its restart flag set and matches while counting makes the next timer value 0xFFFF. Counting continues upward from there. A period of P ticks therefore uses compare value P-2.
- R5: On a match, a cell applies the action selected by `cfg_act`: 0 hold, 1 set, 2 clear, 3 toggle, 4 copy the incoming value. Codes 5 to 7 act as hold.
- R6: A cell with `cfg_link` = 1 takes the new value of the previous cell whenever that cell fires. An unlinked cell ignores the previous cell's events.
- R7: When a linked cell and the cell before it fire in the same cycle, the later cell's action determines its output.
- R8: `cfg_sel` qualifies matches against `sel_in`: 0 always, 1 only while `sel_in` is high, 2 only while it is low, 3 never.
- R9: The edge-aligned configuration gives exactly Ton high cycles in every period of P cycles. In that configuration the trailing cell clears and restarts at P-2, and the linked leading cell sets at P-Ton-2, modulo 2^16. For Ton = 0 the leading compare value is 0xFFFE.
- R10: A channel that does not hold the restart cell reaches 100% duty with its trailing compare value at P-1 and its leading compare value at P-2.
- R11: Center-aligned output with a period of 160, setting at 40 and clearing at 120, is high for 80 of every 160 cycles.
- R12: A configuration write lands on the next clock edge and affects matches from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Timer clock enable; also gates compare events |
| sel_in | input | 1 | Select line used by the match qualifiers |
| tmr_mode | input | 1 | 0 free mode, 1 restart mode |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | IW (2) | Index of the compare cell written |
| cfg_cmp | input | TW (16) | Compare value |
| cfg_act | input | 3 | Match action code |
| cfg_sel | input | 2 | Qualifier code |
| cfg_restart | input | 1 | Cell restarts the timer on a match |
| cfg_link | input | 1 | Cell follows the events of the previous cell |
| tmr_val | output | TW (16) | Timer bus value |
| cell_out | output | NCMP (4) | Registered output of each compare cell; the top bit drives the pin |

## Verification
The assertions assume that `cnt_en` is the only thing that moves the timer. They also assume that a restart can only be raised in a counting cycle, because matches are gated by `cnt_en`. The stimulus reconfigures cells only while `cnt_en` is low, straight after a reset. Every new setting therefore starts from a timer value of zero and a fully known cell state. Duty counts are taken only after several whole periods, so the counting window holds steady-state waveforms only.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

    typedef enum logic [2:0] {
        ACT_HOLD = 3'd0,
        ACT_SET  = 3'd1,
        ACT_CLR  = 3'd2,
        ACT_TOG  = 3'd3,
        ACT_COPY = 3'd4
    } act_e;

    typedef enum logic [1:0] {
        QUAL_ALWAYS = 2'd0,
        QUAL_HIGH   = 2'd1,
        QUAL_LOW    = 2'd2,
        QUAL_NEVER  = 2'd3
    } qual_e;

    typedef struct packed {
        act_e  act;
        qual_e qual;
        logic  restart;
        logic  link;
    } cell_ctl_t;

    localparam cell_ctl_t CTL_RESET = '{act: ACT_HOLD, qual: QUAL_ALWAYS,
                                        restart: 1'b0, link: 1'b0};

    function automatic logic qual_ok(qual_e q, logic sel);
        case (q)
            QUAL_ALWAYS: return 1'b1;
            QUAL_HIGH:   return sel;
            QUAL_LOW:    return !sel;
            default:     return 1'b0;
        endcase
    endfunction

    function automatic logic apply_act(act_e a, logic base, logic incoming);
        case (a)
            ACT_SET:  return 1'b1;
            ACT_CLR:  return 1'b0;
            ACT_TOG:  return !base;
            ACT_COPY: return incoming;
            default:  return base;
        endcase
    endfunction

endpackage

// File: rtl/tcc_timer.sv
module tcc_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          restart,
    output logic [TW-1:0] tmr
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tmr <= '0;
        end else if (cnt_en) begin
            if (restart) tmr <= '1;
            else         tmr <= tmr + 1'b1;
        end
    end
endmodule

// File: rtl/tcc_cmp_cell.sv
module tcc_cmp_cell
    import tcc_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cnt_en,
    input  logic          sel_in,
    input  logic [TW-1:0] tmr,
    input  logic          wr_en,
    input  logic [TW-1:0] wr_cmp,
    input  cell_ctl_t     wr_ctl,
    input  logic          in_val,
    input  logic          in_evt,
    output logic          nxt_val,
    output logic          out_evt,
    output logic          restart_req,
    output logic          q
);
    logic [TW-1:0] cmp_q;
    cell_ctl_t     ctl_q;
    logic          hit;
    logic          take;
    logic          base;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmp_q <= '1;
            ctl_q <= CTL_RESET;
        end else if (wr_en) begin
            cmp_q <= wr_cmp;
            ctl_q <= wr_ctl;
        end
    end

    always_comb begin
        hit         = cnt_en && qual_ok(ctl_q.qual, sel_in) && (tmr == cmp_q);
        take        = ctl_q.link && in_evt;
        base        = take ? in_val : q;
        nxt_val     = hit ? apply_act(ctl_q.act, base, in_val) : base;
        out_evt     = hit || take;
        restart_req = hit && ctl_q.restart;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= nxt_val;
    end
endmodule

// File: rtl/tcc_chain.sv
module tcc_chain
    import tcc_pkg::*;
#(
    parameter int TW   = 16,
    parameter int NCMP = 4,
    localparam int IW  = (NCMP > 1) ? $clog2(NCMP) : 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cnt_en,
    input  logic            sel_in,
    input  logic            tmr_mode,
    input  logic            cfg_we,
    input  logic [IW-1:0]   cfg_idx,
    input  logic [TW-1:0]   cfg_cmp,
    input  logic [2:0]      cfg_act,
    input  logic [1:0]      cfg_sel,
    input  logic            cfg_restart,
    input  logic            cfg_link,
    output logic [TW-1:0]   tmr_val,
    output logic [NCMP-1:0] cell_out
);
    logic [NCMP:0]   val_w;
    logic [NCMP:0]   evt_w;
    logic [NCMP-1:0] rst_vec;
    logic            restart_any;
    cell_ctl_t       wr_ctl;

    assign wr_ctl = '{act: act_e'(cfg_act), qual: qual_e'(cfg_sel),
                      restart: cfg_restart, link: cfg_link};

    // The timer cell drives no signal of its own into the chain.
    assign val_w[0] = 1'b0;
    assign evt_w[0] = 1'b0;

    assign restart_any = tmr_mode && (|rst_vec);

    tcc_timer #(.TW(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .cnt_en  (cnt_en),
        .restart (restart_any),
        .tmr     (tmr_val)
    );

    for (genvar i = 0; i < NCMP; i++) begin : g_cell
        logic wr_hit;
        assign wr_hit = cfg_we && (cfg_idx == IW'(i));

        tcc_cmp_cell #(.TW(TW)) u_cell (
            .clk         (clk),
            .rst         (rst),
            .cnt_en      (cnt_en),
            .sel_in      (sel_in),
            .tmr         (tmr_val),
            .wr_en       (wr_hit),
            .wr_cmp      (cfg_cmp),
            .wr_ctl      (wr_ctl),
            .in_val      (val_w[i]),
            .in_evt      (evt_w[i]),
            .nxt_val     (val_w[i+1]),
            .out_evt     (evt_w[i+1]),
            .restart_req (rst_vec[i]),
            .q           (cell_out[i])
        );
    end
endmodule

// File: rtl/tcc_chain_chk.sv
module tcc_chain_chk #(
    parameter int TW   = 16,
    parameter int NCMP = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            cnt_en,
    input logic            tmr_mode,
    input logic            restart,
    input logic [TW-1:0]   tmr_val,
    input logic [NCMP-1:0] cell_out
);
    // R1: reset clears timer and outputs
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (tmr_val == '0 && cell_out == '0));

    // R2: timer frozen without enable
    a_r2_timer_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(tmr_val));

    // R2: outputs frozen without enable
    a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(cell_out));

    // R2: plain increment when counting without restart
    a_r2_increment: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !restart) |=> (tmr_val == $past(tmr_val) + 1'b1));

    // R3: free mode never restarts
    a_r3_free_no_restart: assert property (@(posedge clk) disable iff (rst)
        !tmr_mode |-> !restart);

    // R4: restart loads all ones
    a_r4_restart_value: assert property (@(posedge clk) disable iff (rst)
        restart |=> (tmr_val == {TW{1'b1}}));

    // R4: restart only happens in a counting cycle
    a_r4_restart_needs_en: assert property (@(posedge clk) disable iff (rst)
        restart |-> cnt_en);
endmodule

bind tcc_chain tcc_chain_chk #(.TW(TW), .NCMP(NCMP)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cnt_en   (cnt_en),
    .tmr_mode (tmr_mode),
    .restart  (restart_any),
    .tmr_val  (tmr_val),
    .cell_out (cell_out)
);

// File: tb/tcc_chain_tb.sv
module tcc_chain_tb;
    localparam int TW   = 16;
    localparam int NCMP = 4;
    localparam int IW   = 2;

    localparam logic [2:0] A_HOLD = 3'd0, A_SET = 3'd1, A_CLR = 3'd2,
                           A_TOG = 3'd3, A_COPY = 3'd4;
    localparam logic [1:0] Q_ALW = 2'd0, Q_HI = 2'd1, Q_LO = 2'd2, Q_NEV = 2'd3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cnt_en = 1'b0;
    logic            sel_in = 1'b0;
    logic            tmr_mode = 1'b0;
    logic            cfg_we = 1'b0;
    logic [IW-1:0]   cfg_idx = '0;
    logic [TW-1:0]   cfg_cmp = '0;
    logic [2:0]      cfg_act = '0;
    logic [1:0]      cfg_sel = '0;
    logic            cfg_restart = 1'b0;
    logic            cfg_link = 1'b0;
    logic [TW-1:0]   tmr_val;
    logic [NCMP-1:0] cell_out;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    tcc_chain #(.TW(TW), .NCMP(NCMP)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .sel_in(sel_in),
        .tmr_mode(tmr_mode), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_cmp(cfg_cmp), .cfg_act(cfg_act), .cfg_sel(cfg_sel),
        .cfg_restart(cfg_restart), .cfg_link(cfg_link),
        .tmr_val(tmr_val), .cell_out(cell_out)
    );

    task automatic chk(input string tag, input int actual, input int expected);
        n_chk++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, actual, expected);
        end
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic fresh(input logic mode);
        cnt_en = 1'b0;
        rst    = 1'b1;
        run(2);
        rst      = 1'b0;
        tmr_mode = mode;
    endtask

    task automatic wcfg(input int idx, input int cmp, input logic [2:0] act,
                        input logic [1:0] q, input logic rf, input logic lk);
        cfg_idx = IW'(idx);
        cfg_cmp = TW'(cmp);
        cfg_act = act;
        cfg_sel = q;
        cfg_restart = rf;
        cfg_link = lk;
        cfg_we = 1'b1;
        run(1);
        cfg_we = 1'b0;
    endtask

    task automatic count_high(input int idx, input int n, output int c);
        c = 0;
        for (int k = 0; k < n; k++) begin
            run(1);
            if (cell_out[idx]) c++;
        end
    endtask

    task automatic wait_tmr(input int v);
        for (int k = 0; k < 70000; k++) begin
            if (tmr_val == TW'(v)) break;
            run(1);
        end
    endtask

    function automatic int lead_cmp(input int p, input int ton);
        if (ton == 0) return 16'hFFFE;
        return (p - ton - 2) & 16'hFFFF;
    endfunction

    initial begin : watchdog
        #(20 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int c;
        int tv;
        int co;

        // R1: reset state
        run(3);
        chk("R1 timer", int'(tmr_val), 0);
        chk("R1 outputs", int'(cell_out), 0);

        // R3: free mode ignores the restart flag; R5 toggle once; R12 write timing
        fresh(1'b0);
        wcfg(0, 5, A_TOG, Q_ALW, 1'b1, 1'b0);
        cnt_en = 1'b1;
        run(10);
        chk("R3 no restart in free mode", int'(tmr_val), 10);
        chk("R12 write then match", int'(cell_out[0]), 1);
        wait_tmr(16'hFFFF);
        chk("R3 reached top", int'(tmr_val), 16'hFFFF);
        run(1);
        chk("R3 wrap", int'(tmr_val), 0);

        // R4: restart forces 0xFFFF then counts up
        fresh(1'b1);
        wcfg(1, 4, A_HOLD, Q_ALW, 1'b1, 1'b0);
        cnt_en = 1'b1;
        wait_tmr(4);
        run(1);
        chk("R4 restart value", int'(tmr_val), 16'hFFFF);
        run(1);
        chk("R4 count after restart", int'(tmr_val), 0);

        // R9: edge-aligned channel holding the restart cell
        for (int p = 7; p <= 10; p += 3) begin
            for (int ton = 0; ton < p; ton++) begin
                fresh(1'b1);
                wcfg(0, p - 2, A_CLR, Q_ALW, 1'b1, 1'b0);
                wcfg(1, lead_cmp(p, ton), A_SET, Q_ALW, 1'b0, 1'b1);
                cnt_en = 1'b1;
                run(3 * p);
                count_high(1, p, c);
                chk($sformatf("R9 duty P=%0d Ton=%0d", p, ton), c, ton);
            end
        end

        // R9/R10: second channel up to 100%
        for (int ton = 0; ton <= 10; ton++) begin
            fresh(1'b1);
            wcfg(0, 8, A_CLR, Q_ALW, 1'b1, 1'b0);
            if (ton == 10) begin
                wcfg(2, 9, A_CLR, Q_ALW, 1'b0, 1'b0);
                wcfg(3, 8, A_SET, Q_ALW, 1'b0, 1'b1);
            end else begin
                wcfg(2, 8, A_CLR, Q_ALW, 1'b0, 1'b0);
                wcfg(3, lead_cmp(10, ton), A_SET, Q_ALW, 1'b0, 1'b1);
            end
            cnt_en = 1'b1;
            run(30);
            count_high(3, 10, c);
            chk($sformatf("R10 second channel Ton=%0d", ton), c, ton);
        end

        // R7: later cell wins on a simultaneous event, both orders
        fresh(1'b1);
        wcfg(0, 8, A_CLR, Q_ALW, 1'b1, 1'b0);
        wcfg(2, 8, A_CLR, Q_ALW, 1'b0, 1'b0);
        wcfg(3, 8, A_SET, Q_ALW, 1'b0, 1'b1);
        cnt_en = 1'b1;
        run(30);
        count_high(3, 10, c);
        chk("R7 set after clear", c, 10);
        fresh(1'b1);
        wcfg(0, 8, A_CLR, Q_ALW, 1'b1, 1'b0);
        wcfg(2, 8, A_SET, Q_ALW, 1'b0, 1'b0);
        wcfg(3, 8, A_CLR, Q_ALW, 1'b0, 1'b1);
        cnt_en = 1'b1;
        run(30);
        count_high(3, 10, c);
        chk("R7 clear after set", c, 0);

        // R11: center aligned 160 / 40 / 120
        fresh(1'b1);
        wcfg(0, 158, A_HOLD, Q_ALW, 1'b1, 1'b0);
        wcfg(2, 40, A_SET, Q_ALW, 1'b0, 1'b0);
        wcfg(3, 120, A_CLR, Q_ALW, 1'b0, 1'b1);
        cnt_en = 1'b1;
        run(400);
        count_high(3, 160, c);
        chk("R11 center duty", c, 80);

        // R5: toggle once per period
        fresh(1'b1);
        wcfg(0, 6, A_TOG, Q_ALW, 1'b1, 1'b0);
        cnt_en = 1'b1;
        run(24);
        count_high(0, 16, c);
        chk("R5 toggle", c, 8);

        // R5 hold: linked hold cell matches mid-pulse without effect
        fresh(1'b1);
        wcfg(0, 6, A_CLR, Q_ALW, 1'b1, 1'b0);
        wcfg(1, 2, A_SET, Q_ALW, 1'b0, 1'b1);
        wcfg(2, 4, A_HOLD, Q_ALW, 1'b0, 1'b1);
        cnt_en = 1'b1;
        run(24);
        count_high(2, 8, c);
        chk("R5 hold", c, 4);

        // R6: unlinked cell ignores the neighbour, copy takes its value
        fresh(1'b1);
        wcfg(3, 6, A_HOLD, Q_ALW, 1'b1, 1'b0);
        wcfg(1, 2, A_SET, Q_ALW, 1'b0, 1'b0);
        wcfg(2, 4, A_COPY, Q_ALW, 1'b0, 1'b0);
        cnt_en = 1'b1;
        wait_tmr(3);
        chk("R6 source set", int'(cell_out[1]), 1);
        chk("R6 unlinked ignores", int'(cell_out[2]), 0);
        wait_tmr(5);
        chk("R6 copy", int'(cell_out[2]), 1);

        // R2: freeze with enable low
        fresh(1'b1);
        wcfg(0, 6, A_TOG, Q_ALW, 1'b1, 1'b0);
        cnt_en = 1'b1;
        run(11);
        cnt_en = 1'b0;
        tv = int'(tmr_val);
        co = int'(cell_out);
        run(15);
        chk("R2 timer frozen", int'(tmr_val), tv);
        chk("R2 outputs frozen", int'(cell_out), co);
        cnt_en = 1'b1;
        run(1);
        chk("R2 resumes", int'(tmr_val), (tv + 1) & 16'hFFFF);

        // R8: qualifier codes against the select line
        for (int m = 0; m < 4; m++) begin
            int exp_c;
            fresh(1'b1);
            wcfg(3, 6, A_HOLD, Q_ALW, 1'b1, 1'b0);
            wcfg(0, 3, A_TOG, (m == 0 || m == 1) ? Q_HI : ((m == 2) ? Q_LO : Q_NEV),
                 1'b0, 1'b0);
            sel_in = (m != 1);
            cnt_en = 1'b1;
            run(24);
            count_high(0, 16, c);
            exp_c = (m == 0) ? 8 : 0;
            chk($sformatf("R8 qualifier case %0d", m), c, exp_c);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule